// File: doc/BRIEF.md
# I2C Register-Write Target

This block is an I2C target that runs entirely on the system clock. It brings the bus clock and data lines in through two-flop synchronizers, recognises START, repeated START and STOP conditions, and shifts bytes in most significant bit first. It answers one 7-bit device address. A strap input picks the address: 0x50 when the strap is low and 0x51 when it is high. When it acknowledges, it pulls the data line low through an open-drain enable output.

A write transaction has three parts: the address byte with a write direction bit, then a register index byte, then one or more data bytes. The data goes into a file of sixteen 8-bit registers. A read transaction returns registers starting at the last index written. The index advances by one after every byte sent. Sending stops when the master answers with a NACK. Typical use is a write of the index followed by a repeated START and a read.

Top module: `i2c_reg_target`

## Requirements
- R1: A START is SDA falling while SCL is high, and a STOP is SDA rising while SCL is high. A START, including a repeated START during a transaction, restarts address reception. This holds even after a mismatched or ignored transfer.
- R2: The first byte after START carries a 7-bit address in bits 7..1 and the direction in bit 0 (0 = write, 1 = read). The address matches 0x50 when `addr_sel` is 0 and 0x51 when it is 1. A match is acknowledged by holding SDA low through the ninth clock.
- R3: A byte whose address does not match gets no acknowledge. Later bytes on the bus get no acknowledge either, until the next START or STOP.
- R4: In a write transaction, the second byte sets the register index and the third byte is stored into the register at that index. Every byte is acknowledged.
- R5: Further data bytes in the same write transaction are also acknowledged. Each one overwrites the register at the same index.
- R6: A write to an index of 16 or more is acknowledged and discarded. No register changes.
- R7: After reset all sixteen registers read 0x00, the index is 0 and SDA is released.
- R8: A read sends the register at the current index, MSB first. The index advances by one after each byte sent, and an index of 16 or more reads as 0x00.
- R9: When the master answers a read byte with a NACK, the target releases SDA. It drives nothing more until the next START or STOP.
- R10: The target changes its SDA drive only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line as seen on the pin |
| sda_i | input | 1 | Bus data line as seen on the pin |
| addr_sel | input | 1 | Address strap: 0 selects 0x50, 1 selects 0x51 |
| sda_oe | output | 1 | When 1, the pad pulls SDA low |

## Verification
The hardest situation to reach is the behaviour after a transfer has been abandoned: a NACK mid-read, or a mismatched address followed by more bytes. Here the target must stay silent and then recover cleanly on the next START. The stimulus reaches it with directed sequences. One clocks a whole extra byte after a NACK and expects an all-ones byte. Another sends a wrong address and then data bytes, and after that a repeated START with the right address. Random transactions mix strap values, out-of-range indices and wrong addresses. A final dump of every register shows that the discarded writes changed nothing.

// File: rtl/i2c_reg_target.sv
module i2c_reg_target #(
  parameter int         NREG      = 16,
  parameter logic [6:0] BASE_ADDR = 7'h50
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  input  logic addr_sel,
  output logic sda_oe
);
  localparam int IW = (NREG > 1) ? $clog2(NREG) : 1;

  typedef enum logic [2:0] {S_IDLE, S_ADR, S_IDX, S_DAT, S_RD, S_IGN} st_t;

  logic [1:0] scl_sy, sda_sy;
  logic       scl_d, sda_d;
  logic       scl_s, sda_s;
  st_t        st;
  logic [3:0] bitcnt;
  logic [7:0] rx, tx, ptr;
  logic       go;
  logic [7:0] regs [NREG];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      scl_sy <= 2'b11;
      sda_sy <= 2'b11;
      scl_d  <= 1'b1;
      sda_d  <= 1'b1;
    end else begin
      scl_sy <= {scl_sy[0], scl_i};
      sda_sy <= {sda_sy[0], sda_i};
      scl_d  <= scl_sy[1];
      sda_d  <= sda_sy[1];
    end

  assign scl_s = scl_sy[1];
  assign sda_s = sda_sy[1];

  wire scl_rise  = scl_s & ~scl_d;
  wire scl_fall  = ~scl_s & scl_d;
  wire start_det = scl_s & scl_d & sda_d & ~sda_s;
  wire stop_det  = scl_s & scl_d & ~sda_d & sda_s;
  wire active    = (st == S_ADR) || (st == S_IDX) || (st == S_DAT) || (st == S_RD);
  wire [6:0] my_addr = BASE_ADDR | {6'b0, addr_sel};
  wire addr_hit  = (rx[7:1] == my_addr);
  wire in_range  = int'(ptr) < NREG;
  wire [7:0] rd_data = in_range ? regs[ptr[IW-1:0]] : 8'h00;
  wire byte_end  = active && scl_fall && (bitcnt == 4'd8) && !start_det && !stop_det;
  wire wr_en     = byte_end && (st == S_DAT) && in_range;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st     <= S_IDLE;
      bitcnt <= '0;
      rx     <= '0;
      tx     <= '0;
      ptr    <= '0;
      go     <= 1'b0;
      sda_oe <= 1'b0;
    end else if (start_det) begin
      st     <= S_ADR;
      bitcnt <= '0;
      sda_oe <= 1'b0;
    end else if (stop_det) begin
      st     <= S_IDLE;
      bitcnt <= '0;
      sda_oe <= 1'b0;
    end else if (active) begin
      if (scl_rise) begin
        if (bitcnt < 4'd8) rx <= {rx[6:0], sda_s};
        else if (st == S_RD) go <= ~sda_s;
        bitcnt <= bitcnt + 4'd1;
      end else if (scl_fall) begin
        if (bitcnt == 4'd8) begin
          case (st)
            S_ADR:
              if (addr_hit) begin
                sda_oe <= 1'b1;
                st     <= rx[0] ? S_RD : S_IDX;
              end else begin
                st <= S_IGN;
              end
            S_IDX: begin
              ptr    <= rx;
              sda_oe <= 1'b1;
              st     <= S_DAT;
            end
            S_DAT:   sda_oe <= 1'b1;
            S_RD: begin
              sda_oe <= 1'b0;
              ptr    <= ptr + 8'd1;
            end
            default: sda_oe <= 1'b0;
          endcase
        end else if (bitcnt == 4'd9) begin
          bitcnt <= '0;
          if (st == S_RD && go) begin
            sda_oe <= ~rd_data[7];
            tx     <= {rd_data[6:0], 1'b0};
          end else if (st == S_RD) begin
            sda_oe <= 1'b0;
            st     <= S_IGN;
          end else begin
            sda_oe <= 1'b0;
          end
        end else if (st == S_RD && bitcnt != 4'd0) begin
          sda_oe <= ~tx[7];
          tx     <= {tx[6:0], 1'b0};
        end
      end
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) regs[i] <= '0;
    end else if (wr_en) begin
      regs[ptr[IW-1:0]] <= rx;
    end

  p_start_restarts_r1: assert property (@(posedge clk) disable iff (!rst_n)
    start_det |=> (st == S_ADR) && (bitcnt == 4'd0) && !sda_oe);

  p_stop_frees_r1: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> (st == S_IDLE) && !sda_oe);

  p_ack_in_ninth_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) && ($past(st) != S_RD) |-> (bitcnt == 4'd8));

  p_ignore_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IGN) |-> !sda_oe);

  p_drive_scl_low_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe) && !$past(start_det) && !$past(stop_det) |-> !scl_d);
endmodule

// File: tb/test_i2c_reg_target.sv
module test_i2c_reg_target;
  localparam int CLK_PERIOD = 10;
  localparam int Q = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl = 1'b1;
  logic sda_m = 1'b1;
  logic sel = 1'b0;
  logic sda_oe;
  wire  sda_line = sda_m & ~sda_oe;

  int vecs = 0;
  int errs = 0;
  int r10_bad = 0;
  logic [7:0] mem [16];
  logic [7:0] mptr = 8'h00;
  logic oe_q = 1'b0;

  i2c_reg_target i_i2c_reg_target (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line),
    .addr_sel(sel), .sda_oe(sda_oe)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(negedge clk) begin
    if (sda_oe !== oe_q && scl) r10_bad++;
    oe_q <= sda_oe;
  end

  function automatic logic [7:0] exp_rd(input logic [7:0] p);
    return (p < 8'd16) ? mem[p[3:0]] : 8'h00;
  endfunction

  function automatic logic [6:0] my_addr();
    return sel ? 7'h51 : 7'h50;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    vecs++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: got %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wq();
    repeat (Q) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; wq(); scl = 1'b1; wq(); sda_m = 1'b0; wq(); scl = 1'b0; wq();
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; wq(); scl = 1'b1; wq(); sda_m = 1'b1; wq();
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; wq(); scl = 1'b1; wq(); wq(); scl = 1'b0; wq();
    end
    sda_m = 1'b1; wq(); scl = 1'b1; wq(); ack = ~sda_line; wq(); scl = 1'b0; wq();
  endtask

  task automatic recv_byte(input logic mack, output logic [7:0] b);
    sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      wq(); scl = 1'b1; wq(); b[i] = sda_line; wq(); scl = 1'b0;
    end
    wq(); sda_m = ~mack; wq(); scl = 1'b1; wq(); wq(); scl = 1'b0; wq(); sda_m = 1'b1;
  endtask

  task automatic do_write(input logic [7:0] idx, input logic [7:0] d0,
                          input bit extra, input logic [7:0] d1);
    logic a;
    bus_start();
    send_byte({my_addr(), 1'b0}, a); chk("R2 address ack", a, 1);
    send_byte(idx, a);               chk("R4 index ack", a, 1);
    send_byte(d0, a);                chk(idx >= 16 ? "R6 discarded data ack" : "R4 data ack", a, 1);
    if (idx < 16) mem[idx[3:0]] = d0;
    if (extra) begin
      send_byte(d1, a);              chk("R5 extra data ack", a, 1);
      if (idx < 16) mem[idx[3:0]] = d1;
    end
    mptr = idx;
    bus_stop();
  endtask

  task automatic do_read(input logic [7:0] idx, input int n);
    logic a;
    logic [7:0] b;
    bus_start();
    send_byte({my_addr(), 1'b0}, a); chk("R2 address ack", a, 1);
    send_byte(idx, a);               chk("R4 index ack", a, 1);
    mptr = idx;
    bus_start();
    send_byte({my_addr(), 1'b1}, a); chk("R1 repeated START read ack", a, 1);
    for (int k = 0; k < n; k++) begin
      recv_byte(k < n - 1, b);
      chk("R8 read data", b, exp_rd(mptr));
      mptr = mptr + 8'd1;
    end
    bus_stop();
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errs++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

  initial begin
    logic a;
    logic [7:0] b;
    void'($urandom(32'd4711));
    for (int i = 0; i < 16; i++) mem[i] = 8'h00;
    repeat (5) @(negedge clk);
    chk("R7 SDA released in reset", sda_oe, 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // R7: read straight after reset from index 0
    bus_start();
    send_byte({7'h50, 1'b1}, a); chk("R7 read address ack", a, 1);
    for (int k = 0; k < 4; k++) begin
      recv_byte(k < 3, b); chk("R7 reset value", b, 8'h00);
    end
    bus_stop();
    mptr = 8'd4;

    // R2: strap picks the address
    sel = 1'b0;
    bus_start(); send_byte({7'h51, 1'b0}, a); chk("R2 0x51 rejected with strap low", a, 0); bus_stop();
    sel = 1'b1;
    bus_start(); send_byte({7'h50, 1'b0}, a); chk("R2 0x50 rejected with strap high", a, 0); bus_stop();
    do_write(8'd2, 8'hA5, 0, 8'h00);
    sel = 1'b0;
    do_read(8'd2, 1);

    // R3 and R1: wrong address, ignored bytes, repeated START recovers
    bus_start();
    send_byte({7'h52, 1'b0}, a); chk("R3 mismatch no ack", a, 0);
    send_byte(8'h05, a);         chk("R3 ignored byte no ack", a, 0);
    bus_start();
    send_byte({7'h50, 1'b0}, a); chk("R1 repeated START after ignore", a, 1);
    send_byte(8'h07, a);         chk("R4 index ack", a, 1);
    send_byte(8'h3C, a);         chk("R4 data ack", a, 1);
    mem[7] = 8'h3C; mptr = 8'd7;
    bus_stop();

    // R5: extra data byte overwrites same register
    do_write(8'd3, 8'h11, 1, 8'h22);
    do_read(8'd2, 3);

    // R6 and R8: out of range write and read
    do_write(8'd200, 8'hEE, 0, 8'h00);
    do_read(8'd15, 3);

    // R9: NACK ends sending, extra byte reads all ones
    bus_start();
    send_byte({7'h50, 1'b0}, a); send_byte(8'd3, a);
    bus_start();
    send_byte({7'h50, 1'b1}, a); chk("R9 read address ack", a, 1);
    recv_byte(1'b0, b);          chk("R9 byte before NACK", b, 8'h22);
    recv_byte(1'b0, b);          chk("R9 released after NACK", b, 8'hFF);
    bus_stop();
    mptr = 8'd4;

    // Random mix
    for (int it = 0; it < 70; it++) begin
      int op;
      sel = 1'($urandom % 2);
      op = $urandom % 4;
      if (op < 2) begin
        do_write(8'($urandom % 20), 8'($urandom), bit'($urandom % 2), 8'($urandom));
      end else if (op == 2) begin
        do_read(8'($urandom % 20), 1 + ($urandom % 3));
      end else begin
        logic [6:0] bad;
        bad = 7'h52 + 7'($urandom % 8);
        bus_start();
        send_byte({bad, 1'($urandom % 2)}, a); chk("R3 mismatch no ack", a, 0);
        send_byte(8'($urandom), a);            chk("R3 ignored byte no ack", a, 0);
        bus_stop();
      end
    end

    // Full dump: discarded and ignored traffic changed nothing
    sel = 1'b0;
    do_read(8'd0, 16);
    chk("R10 SDA drive changed with SCL high", r10_bad, 0);

    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end
endmodule